// File: doc/BRIEF.md
# Multichannel Converter Channel Sequencer

This block chooses which of the analog inputs a multichannel converter samples in each conversion frame. One frame arrives per valid chip-select falling edge. The frame carries a write flag and, when that flag is set, a control word that has already been deserialized. The block answers every frame with one channel number. That number was decided by the state that existed before the frame. Any write in the frame then shapes the channels of later frames.

There are four ways of choosing channels. The first converts a single addressed channel. The second loads a bit mask from the frame after a control write and then cycles through the channels marked in it. The third sweeps from channel 0 up to a programmed last channel. The fourth accepts a control write without disturbing a sequence that is already running.

Frames enter on a valid/ready port. A frame is taken only on a cycle where `frm_valid` and `frm_ready` are both high. Channel numbers leave on a second valid/ready port with a one-entry output register. While a channel number waits for `ch_ready`, `frm_ready` stays low, so no frame is lost or reordered. The empty-mask status pin is a plain level.

Top module: `chsq_top`

## Requirements
- R1: After synchronous reset, `ch_valid` and `mask_empty` are low and `frm_ready` is high. The first frame yields channel 0, and the mode is single-channel.
- R2: In single-channel mode, every frame yields the address set by the most recent control write. A frame without a write yields the same channel again.
- R3: The control word fields are: bits [3:0] the channel address (0000 selects channel 0, 1111 selects channel 15), bit 4 the mask flag, bit 5 the sequence flag. Bits 15:6 have no effect on the channel stream.
- R4: A write with sequence=0 and mask=1 makes the block treat the next frame's word as the channel mask. It does not decode that word as a control word, even when its bits 5:4 are set.
- R5: After a mask is loaded, later frames visit the set mask bits in ascending order and wrap to the lowest set bit. Bit i set means channel i is included, and the channels need not be adjacent.
- R6: Loading an all-zero mask makes every later frame yield channel 0 and raises `mask_empty`. A later control write with the sequence flag clear clears `mask_empty`.
- R7: A write with sequence=1 and mask=1 starts a sweep. The frames after it yield 0, 1, and so on up to the written address, then wrap to 0. This holds for a last channel of 15.
- R8: A write with sequence=1 and mask=0 neither restarts nor alters a running mask or sweep sequence. When no sequence is running, it selects the written address just as a plain single-channel write does.
- R9: While `ch_valid` is high and `ch_ready` is low, `ch_num` and `ch_valid` hold and `frm_ready` is low. Each accepted frame produces exactly one channel number, in order.
- R10: The wait for a mask lasts exactly one frame. If that frame carries no write, the load is dropped and the next written word is decoded as a control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | A frame (chip-select falling edge) is offered |
| frm_ready | output | 1 | The block can take a frame |
| frm_wr | input | 1 | The frame carries a write |
| frm_word | input | 16 | Deserialized control word or mask |
| ch_valid | output | 1 | Channel number available |
| ch_ready | input | 1 | Consumer takes the channel number |
| ch_num | output | 4 | Channel to convert in the accepted frame |
| mask_empty | output | 1 | The loaded channel mask had no bits set |

## Verification
The bench builds the block with the default of 16 channels. At that size the 4-bit address reaches channel 15, a sweep to the top channel wraps, and a mask with bit 0 and bit 15 set exercises both ends of the ascending scan. The bench also throttles `ch_ready` on alternate cycles during a mask sequence. This checks that back-pressure stalls frame intake without reordering the channel stream.

// File: rtl/chsq_pkg.sv
package chsq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_MASK   = 2'd1,
    MODE_SWEEP  = 2'd2
  } seq_mode_e;

  // {sequence flag, mask flag} as decoded from a control word
  localparam logic [1:0] CMD_PLAIN  = 2'b00;
  localparam logic [1:0] CMD_LOADM  = 2'b01;
  localparam logic [1:0] CMD_KEEP   = 2'b10;
  localparam logic [1:0] CMD_SWEEP  = 2'b11;
endpackage

// File: rtl/chsq_mask_scan.sv
module chsq_mask_scan #(
  parameter int N  = 16,
  parameter int AW = 4
) (
  input  logic [N-1:0]  mask,
  input  logic [AW-1:0] from,
  output logic [AW-1:0] pick,
  output logic          hit
);
  // First set bit strictly after 'from', wrapping; 'from' itself is tried last.
  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int k = N; k >= 1; k--) begin
      int idx;
      idx = int'(from) + k;
      if (idx >= N) idx = idx - N;
      if (mask[idx]) begin
        pick = AW'(idx);
        hit  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/chsq_out_reg.sv
module chsq_out_reg #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] din,
  output logic          can_load,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_data
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/chsq_top.sv
module chsq_top #(
  parameter int NCH = 16,
  localparam int AW = $clog2(NCH),
  localparam int WW = NCH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frm_valid,
  output logic          frm_ready,
  input  logic          frm_wr,
  input  logic [WW-1:0] frm_word,
  output logic          ch_valid,
  input  logic          ch_ready,
  output logic [AW-1:0] ch_num,
  output logic          mask_empty
);
  import chsq_pkg::*;

  localparam int MASK_BIT = AW;
  localparam int SEQ_BIT  = AW + 1;

  seq_mode_e       mode;
  logic [AW-1:0]   nxt, last, adv;
  logic [NCH-1:0]  mask;
  logic            want_mask;
  logic            take;
  logic [AW-1:0]   w_addr;
  logic [1:0]      w_cmd;
  logic [AW-1:0]   scan_pick, low_pick;
  logic            scan_hit, low_hit;

  assign take   = frm_valid && frm_ready;
  assign w_addr = frm_word[AW-1:0];
  assign w_cmd  = {frm_word[SEQ_BIT], frm_word[MASK_BIT]};

  chsq_mask_scan #(.N(NCH), .AW(AW)) u_scan (
    .mask(mask), .from(nxt), .pick(scan_pick), .hit(scan_hit));

  chsq_mask_scan #(.N(NCH), .AW(AW)) u_low (
    .mask(frm_word[NCH-1:0]), .from(AW'(NCH - 1)), .pick(low_pick), .hit(low_hit));

  always_comb begin
    case (mode)
      MODE_SWEEP: adv = (nxt == last) ? '0 : nxt + 1'b1;
      MODE_MASK:  adv = scan_hit ? scan_pick : '0;
      default:    adv = nxt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= MODE_SINGLE;
      nxt        <= '0;
      last       <= '0;
      mask       <= '0;
      want_mask  <= 1'b0;
      mask_empty <= 1'b0;
    end else if (take) begin
      want_mask <= 1'b0;
      if (want_mask) begin
        if (frm_wr) begin
          mask       <= frm_word[NCH-1:0];
          mode       <= MODE_MASK;
          nxt        <= low_hit ? low_pick : '0;
          mask_empty <= !low_hit;
        end
      end else if (frm_wr) begin
        case (w_cmd)
          CMD_PLAIN: begin
            mode <= MODE_SINGLE; nxt <= w_addr; mask_empty <= 1'b0;
          end
          CMD_LOADM: begin
            mode <= MODE_SINGLE; nxt <= w_addr; mask_empty <= 1'b0;
            want_mask <= 1'b1;
          end
          CMD_KEEP: nxt <= (mode == MODE_SINGLE) ? w_addr : adv;
          default: begin
            mode <= MODE_SWEEP; last <= w_addr; nxt <= '0; mask_empty <= 1'b0;
          end
        endcase
      end else begin
        nxt <= adv;
      end
    end
  end

  chsq_out_reg #(.AW(AW)) u_out (
    .clk(clk), .rst(rst), .load(take), .din(nxt), .can_load(frm_ready),
    .out_valid(ch_valid), .out_ready(ch_ready), .out_data(ch_num));

  assert_sweep_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SWEEP) |-> (nxt <= last));
  assert_mask_member_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_MASK && !mask_empty) |-> mask[nxt]);
  assert_empty_zero_R6: assert property (@(posedge clk) disable iff (rst)
    mask_empty |-> (nxt == '0 && mode == MODE_MASK));
  assert_wait_one_R10: assert property (@(posedge clk) disable iff (rst)
    (want_mask && take) |=> !want_mask);
  assert_no_take_full_R9: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && !ch_ready) |-> !frm_ready);
endmodule

// File: tb/test_chsq_top.sv
module test_chsq_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_valid = 1'b0, frm_wr = 1'b0, ch_ready = 1'b1;
  logic [15:0] frm_word = '0;
  logic frm_ready, ch_valid, mask_empty;
  logic [3:0] ch_num;

  int checks = 0, fails = 0;
  int exp_q[$];
  string req_q[$];
  bit stall_en = 0;
  int cyc = 0;

  // bench model of the requirements
  int m_nxt = 0, m_last = 0, m_mode = 0; // 0 single, 1 mask, 2 sweep
  bit [15:0] m_mask = '0;
  bit m_want = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chsq_top #(.NCH(NCH)) i_chsq_top (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_wr(frm_wr), .frm_word(frm_word), .ch_valid(ch_valid),
    .ch_ready(ch_ready), .ch_num(ch_num), .mask_empty(mask_empty));

  function automatic int m_adv();
    if (m_mode == 2) return (m_nxt == m_last) ? 0 : m_nxt + 1;
    if (m_mode == 1) begin
      for (int k = 1; k <= 16; k++)
        if (m_mask[(m_nxt + k) % 16]) return (m_nxt + k) % 16;
      return 0;
    end
    return m_nxt;
  endfunction

  function automatic void m_step(bit wr, logic [15:0] w);
    bit was_want = m_want;
    m_want = 0;
    if (was_want) begin
      if (wr) begin
        m_mask = w; m_mode = 1; m_nxt = 0;
        for (int i = 15; i >= 0; i--) if (w[i]) m_nxt = i;
      end
    end else if (wr) begin
      case (w[5:4])
        2'b00: begin m_mode = 0; m_nxt = w[3:0]; end
        2'b01: begin m_mode = 0; m_nxt = w[3:0]; m_want = 1; end
        2'b10: m_nxt = (m_mode == 0) ? int'(w[3:0]) : m_adv();
        default: begin m_mode = 2; m_last = w[3:0]; m_nxt = 0; end
      endcase
    end else m_nxt = m_adv();
  endfunction

  task automatic send(bit wr, logic [15:0] w, string req);
    @(negedge clk);
    frm_valid = 1'b1; frm_wr = wr; frm_word = w;
    while (!frm_ready) @(negedge clk);
    exp_q.push_back(m_nxt);
    req_q.push_back(req);
    m_step(wr, w);
    @(posedge clk);
    #1 frm_valid = 1'b0;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && ch_valid && ch_ready) begin
      if (exp_q.size() == 0) check("R9 unexpected output", 1, 0);
      else begin
        string r = req_q.pop_front();
        check(r, int'(ch_num), exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 ch_ready = stall_en ? cyc[0] : 1'b1;
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 ch_valid after reset", ch_valid, 0);
    check("R1 mask_empty after reset", mask_empty, 0);
    check("R1 frm_ready after reset", frm_ready, 1);
    send(0, 16'h0000, "R1 first channel");
    send(0, 16'h0000, "R1 idle repeat");
    // R2 / R3: plain writes, upper bits ignored
    send(1, 16'h0005, "R2 write addr 5");
    send(0, 16'h0000, "R2 addr 5 used");
    send(0, 16'h0000, "R2 repeat 5");
    send(1, 16'hFFCF, "R3 upper bits ignored, addr 15");
    send(0, 16'h0000, "R3 addr 15 used");
    // R4 / R5: mask load with non-adjacent channels 0,5,10,15
    send(1, 16'h0013, "R4 mask load request");
    send(1, 16'h8421, "R4 mask word frame");
    for (int i = 0; i < 5; i++) send(0, 16'h0000, "R5 mask sequence");
    // R8: keep-write mid-sequence
    send(1, 16'h0029, "R8 keep write in mask sequence");
    for (int i = 0; i < 3; i++) send(0, 16'h0000, "R8 sequence continues");
    // R9: back-pressure
    stall_en = 1;
    for (int i = 0; i < 6; i++) send(0, 16'h0000, "R9 stalled mask sequence");
    drain();
    stall_en = 0;
    // R7: sweep to 3, keep-write mid-sweep
    send(1, 16'h0033, "R7 sweep to 3");
    for (int i = 0; i < 3; i++) send(0, 16'h0000, "R7 sweep");
    send(1, 16'hFC2C, "R8 keep write in sweep");
    for (int i = 0; i < 4; i++) send(0, 16'h0000, "R7 sweep wrap");
    // R7 boundary: sweep to 15
    send(1, 16'h003F, "R7 sweep to 15");
    for (int i = 0; i < 18; i++) send(0, 16'h0000, "R7 sweep top wrap");
    // R8: keep-write with no sequence acts as plain
    send(1, 16'h0002, "R8 plain 2");
    send(1, 16'h002C, "R8 keep write single mode");
    send(0, 16'h0000, "R8 addr 12 used");
    // R4: mask word with bits 5:4 set is a mask
    send(1, 16'h0011, "R4 request");
    send(1, 16'h0030, "R4 mask 0x0030");
    for (int i = 0; i < 3; i++) send(0, 16'h0000, "R4 mask not control");
    // R10: abandoned load
    send(1, 16'h0017, "R10 request");
    send(0, 16'h0000, "R10 frame without write");
    send(1, 16'h0009, "R10 control decoded");
    send(0, 16'h0000, "R10 addr 9 used");
    drain();
    // R6: empty mask
    send(1, 16'h0014, "R6 request");
    send(1, 16'h0000, "R6 zero mask");
    drain();
    check("R6 mask_empty raised", mask_empty, 1);
    send(0, 16'h0000, "R6 channel 0");
    send(0, 16'h0000, "R6 channel 0 again");
    send(1, 16'h0006, "R6 plain write");
    drain();
    check("R6 mask_empty cleared", mask_empty, 0);
    send(0, 16'h0000, "R6 addr 6 used");
    drain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule